// File: doc/BRIEF.md
# System Clock Mode Controller

This block produces the single clock-enable stream that paces a small controller core. It picks one of three oscillator sources: an on-chip RC oscillator, a main crystal input or a 32 kHz sub-clock input. It divides the chosen source by a ratio that depends on the speed mode and pulses `clk_en` once per divided period. The analog oscillators sit outside the block. Each one is seen as a one-cycle tick input, and the block drives an enable output back to each oscillator. No clock is ever gated. Every switch happens on the enable path.

Software changes the mode by writing a 6-bit control word. A write is taken only if it flips exactly one bit and the new state is a legal neighbour of the current one. The source being left must stay running, and the source being entered must already be running and, for the main crystal, stable. Any other write is refused: the control word stays as it was and a sticky error flag is set. The block also has a wait state, where the oscillators keep running and the enable is held low, and a stop state, where all oscillators halt. On release from stop, a delay counted in source ticks must elapse before the clock resumes. The length of that delay depends on the speed mode and on a count-source select input.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset the control word is 0x11 and all outputs other than `ctrl_q` read as follows: `err_flag` 0, `pwr_state` 0 (run), `main_ready` 0, `rc_on` 1, `main_on` 0, `sub_on` 0. In the control word, bits [1:0] hold the divider code, bit 2 is main-source select, bit 3 is sub run, bit 4 is main stop and bit 5 is RC stop. So 0x11 means middle speed on the RC oscillator, with the main and sub oscillators stopped.
- R2: `clk_en` pulses once per RATIO_HIGH (2) ticks of the selected source for divider code 00, once per RATIO_MID (8) ticks for code 01, and once per RATIO_LOW (2) sub ticks for code 10.
- R3: Divider codes 00 and 01 take their ticks from the RC oscillator when bit 2 is 0 and from the main input when bit 2 is 1. Code 10 takes its ticks from the sub input. Ticks from the unselected sources have no effect on `clk_en`.
- R4: `rc_on` = !bit5, `main_on` = !bit4 and `sub_on` = bit3 whenever the block is not in stop. Ticks from an oscillator whose enable is low are ignored.
- R5: A write that changes zero bits or more than one bit is refused.
- R6: A write that would make the divider code 11 is refused, and the control word never holds 11.
- R7: These single-bit writes are refused:
  - entering code 10 unless the sub oscillator runs;
  - clearing sub run while in code 10;
  - stopping the main oscillator while it feeds code 00 or 01;
  - stopping the RC oscillator while it feeds code 00 or 01;
  - leaving code 10 unless the selected main or RC source is usable.
- R8: After the main oscillator is started, `main_ready` rises only after STAB_TICKS main ticks. Selecting the main source (setting bit 2) is refused until `main_ready` is 1.
- R9: A refused write leaves the control word unchanged and sets `err_flag`. The flag stays set until `err_clr` is pulsed, and a new refusal in the same cycle as `err_clr` keeps it set.
- R10: `wait_req` in run enters wait (`pwr_state` 1). In wait `clk_en` stays low while the oscillators run. `wake_evt` returns to run at once with the control word unchanged.
- R11: `stop_req` in run enters stop (`pwr_state` 2). In stop all oscillator enables and `clk_en` are low, and writes are refused.
- R12: `wake_evt` in stop enters the wake delay (`pwr_state` 3). In codes 00 and 01 the block returns to run after WAKE_FAST ticks of the selected source.
- R13: In code 10 the wake delay is WAKE_SUB0 sub ticks when `cnt_sel` is 0 and WAKE_SUB1 sub ticks when `cnt_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Requested control word |
| err_clr | input | 1 | Clears the sticky error flag |
| cnt_sel | input | 1 | Selects the long or short wake delay in low speed |
| wait_req | input | 1 | Request to enter wait |
| stop_req | input | 1 | Request to enter stop |
| wake_evt | input | 1 | Release from wait or stop |
| rc_tick | input | 1 | One-cycle tick from the on-chip oscillator |
| main_tick | input | 1 | One-cycle tick from the main crystal oscillator |
| sub_tick | input | 1 | One-cycle tick from the 32 kHz oscillator |
| clk_en | output | 1 | Divided clock-enable pulse |
| ctrl_q | output | 6 | Current control word |
| err_flag | output | 1 | Sticky refused-write flag |
| main_ready | output | 1 | Main oscillator stabilized |
| pwr_state | output | 2 | 0 run, 1 wait, 2 stop, 3 wake delay |
| rc_on | output | 1 | On-chip oscillator enable |
| main_on | output | 1 | Main oscillator enable |
| sub_on | output | 1 | Sub oscillator enable |

## Verification
The bench keeps the default division ratios. It shrinks the main stabilization count to 4 and the wake delays to 6, 3 and 10 ticks. With these values, a test can end one tick short of each delay and one tick after it, in every speed mode, within a few dozen cycles. Each delay bound is therefore seen on both sides. Because the three delay lengths differ, a test also shows which of them the block picked.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int CW = 6;
  localparam int B_DIV0  = 0;
  localparam int B_DIV1  = 1;
  localparam int B_SRC   = 2;
  localparam int B_SUB   = 3;
  localparam int B_MSTOP = 4;
  localparam int B_RSTOP = 5;

  localparam logic [1:0] DIV_HIGH = 2'b00;
  localparam logic [1:0] DIV_MID  = 2'b01;
  localparam logic [1:0] DIV_LOW  = 2'b10;
  localparam logic [1:0] DIV_RSV  = 2'b11;

  localparam logic [CW-1:0] CTRL_RST = 6'b010001;

  localparam int OSC_N    = 3;
  localparam int OSC_RC   = 0;
  localparam int OSC_MAIN = 1;
  localparam int OSC_SUB  = 2;

  typedef enum logic [1:0] {
    PW_RUN  = 2'd0,
    PW_WAIT = 2'd1,
    PW_STOP = 2'd2,
    PW_WAKE = 2'd3
  } pwr_t;
endpackage

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg
  import sysclk_pkg::*;
#(
  parameter int STAB_TICKS = 8192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          err_clr,
  input  logic          in_run,
  input  logic          main_tk,
  output logic [CW-1:0] ctrl_q,
  output logic          err_q,
  output logic          ready_q,
  output logic          accept
);
  localparam int SW = $clog2(STAB_TICKS + 1);

  logic [CW-1:0] diff;
  logic          ok;
  logic          main_good;
  logic          rc_good;
  logic          low_now;
  logic [SW-1:0] stab_cnt;

  always_comb begin
    diff      = ctrl_q ^ wr_data;
    main_good = !ctrl_q[B_MSTOP] && ready_q;
    rc_good   = !ctrl_q[B_RSTOP];
    low_now   = (ctrl_q[B_DIV1:B_DIV0] == DIV_LOW);
    ok = in_run && ($countones(diff) == 1) &&
         (wr_data[B_DIV1:B_DIV0] != DIV_RSV);
    if (diff[B_DIV0])
      ok = ok && !ctrl_q[B_DIV1];
    if (diff[B_DIV1]) begin
      if (wr_data[B_DIV1:B_DIV0] == DIV_LOW)
        ok = ok && ctrl_q[B_SUB];
      else
        ok = ok && (ctrl_q[B_SRC] ? main_good : rc_good);
    end
    if (diff[B_SRC])
      ok = ok && (wr_data[B_SRC] ? main_good : rc_good);
    if (diff[B_SUB] && !wr_data[B_SUB])
      ok = ok && !low_now;
    if (diff[B_MSTOP] && wr_data[B_MSTOP])
      ok = ok && !(ctrl_q[B_SRC] && !low_now);
    if (diff[B_RSTOP] && wr_data[B_RSTOP])
      ok = ok && !(!ctrl_q[B_SRC] && !low_now);
    accept = wr_en && ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      err_q  <= 1'b0;
    end else begin
      if (accept)
        ctrl_q <= wr_data;
      if (wr_en && !ok)
        err_q <= 1'b1;
      else if (err_clr)
        err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl_q[B_MSTOP]) begin
      stab_cnt <= '0;
      ready_q  <= 1'b0;
    end else if (!ready_q && main_tk) begin
      if (stab_cnt == SW'(STAB_TICKS - 1))
        ready_q <= 1'b1;
      else
        stab_cnt <= stab_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_pkg::*;
#(
  parameter int RATIO_HIGH = 2,
  parameter int RATIO_MID  = 8,
  parameter int RATIO_LOW  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] div,
  input  logic       gate,
  output logic       clk_en
);
  localparam int RMAX = (RATIO_HIGH > RATIO_MID) ?
                        ((RATIO_HIGH > RATIO_LOW) ? RATIO_HIGH : RATIO_LOW) :
                        ((RATIO_MID > RATIO_LOW) ? RATIO_MID : RATIO_LOW);
  localparam int DW = $clog2(RMAX + 1);

  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;
  logic          wrap;

  always_comb begin
    unique case (div)
      DIV_HIGH: lim = DW'(RATIO_HIGH - 1);
      DIV_MID:  lim = DW'(RATIO_MID - 1);
      default:  lim = DW'(RATIO_LOW - 1);
    endcase
    wrap = tick && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      clk_en <= 1'b0;
    end else begin
      if (tick)
        cnt <= wrap ? '0 : cnt + 1'b1;
      clk_en <= wrap && gate;
    end
  end
endmodule

// File: rtl/sysclk_power.sv
module sysclk_power
  import sysclk_pkg::*;
#(
  parameter int WAKE_FAST = 8000,
  parameter int WAKE_SUB0 = 512,
  parameter int WAKE_SUB1 = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_req,
  input  logic stop_req,
  input  logic wake_evt,
  input  logic src_tick,
  input  logic low_mode,
  input  logic cnt_sel,
  output pwr_t st_q,
  output pwr_t st_nxt
);
  localparam int WMAX = (WAKE_FAST > WAKE_SUB0) ?
                        ((WAKE_FAST > WAKE_SUB1) ? WAKE_FAST : WAKE_SUB1) :
                        ((WAKE_SUB0 > WAKE_SUB1) ? WAKE_SUB0 : WAKE_SUB1);
  localparam int WW = $clog2(WMAX + 1);

  logic [WW-1:0] wcnt;
  logic [WW-1:0] wlim;
  logic          wdone;

  assign wdone = src_tick && (wcnt == wlim);

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      PW_RUN: begin
        if (stop_req)      st_nxt = PW_STOP;
        else if (wait_req) st_nxt = PW_WAIT;
      end
      PW_WAIT: if (wake_evt) st_nxt = PW_RUN;
      PW_STOP: if (wake_evt) st_nxt = PW_WAKE;
      PW_WAKE: if (wdone)    st_nxt = PW_RUN;
      default: st_nxt = PW_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PW_RUN;
      wcnt <= '0;
      wlim <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_q == PW_STOP) begin
        wcnt <= '0;
        if (low_mode)
          wlim <= cnt_sel ? WW'(WAKE_SUB1 - 1) : WW'(WAKE_SUB0 - 1);
        else
          wlim <= WW'(WAKE_FAST - 1);
      end else if (st_q == PW_WAKE && src_tick && !wdone) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter int RATIO_HIGH = 2,
  parameter int RATIO_MID  = 8,
  parameter int RATIO_LOW  = 2,
  parameter int STAB_TICKS = 8192,
  parameter int WAKE_FAST  = 8000,
  parameter int WAKE_SUB0  = 512,
  parameter int WAKE_SUB1  = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [5:0] wr_data,
  input  logic       err_clr,
  input  logic       cnt_sel,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       wake_evt,
  input  logic       rc_tick,
  input  logic       main_tick,
  input  logic       sub_tick,
  output logic       clk_en,
  output logic [5:0] ctrl_q,
  output logic       err_flag,
  output logic       main_ready,
  output logic [1:0] pwr_state,
  output logic       rc_on,
  output logic       main_on,
  output logic       sub_on
);
  pwr_t               st_q;
  pwr_t               st_nxt;
  logic               accept;
  logic [OSC_N-1:0]   raw_tk;
  logic [OSC_N-1:0]   osc_en;
  logic [OSC_N-1:0]   tk_ok;
  logic               sel_tk;
  logic               low_mode;
  logic               div_clr;

  assign raw_tk = {sub_tick, main_tick, rc_tick};
  assign osc_en[OSC_RC]   = !ctrl_q[B_RSTOP];
  assign osc_en[OSC_MAIN] = !ctrl_q[B_MSTOP];
  assign osc_en[OSC_SUB]  = ctrl_q[B_SUB];

  for (genvar i = 0; i < OSC_N; i++) begin : g_osc
    assign tk_ok[i] = raw_tk[i] && osc_en[i] && (st_q != PW_STOP);
  end

  assign rc_on   = osc_en[OSC_RC]   && (st_q != PW_STOP);
  assign main_on = osc_en[OSC_MAIN] && (st_q != PW_STOP);
  assign sub_on  = osc_en[OSC_SUB]  && (st_q != PW_STOP);

  assign low_mode = (ctrl_q[B_DIV1:B_DIV0] == DIV_LOW);
  assign sel_tk   = low_mode ? tk_ok[OSC_SUB] :
                    (ctrl_q[B_SRC] ? tk_ok[OSC_MAIN] : tk_ok[OSC_RC]);
  assign div_clr  = accept || (st_q == PW_STOP) || (st_q == PW_WAKE);
  assign pwr_state = st_q;

  sysclk_ctrl_reg #(.STAB_TICKS(STAB_TICKS)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .err_clr (err_clr),
    .in_run  (st_q == PW_RUN),
    .main_tk (tk_ok[OSC_MAIN]),
    .ctrl_q  (ctrl_q),
    .err_q   (err_flag),
    .ready_q (main_ready),
    .accept  (accept)
  );

  sysclk_divider #(
    .RATIO_HIGH (RATIO_HIGH),
    .RATIO_MID  (RATIO_MID),
    .RATIO_LOW  (RATIO_LOW)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .clr    (div_clr),
    .tick   (sel_tk),
    .div    (ctrl_q[B_DIV1:B_DIV0]),
    .gate   (st_nxt == PW_RUN),
    .clk_en (clk_en)
  );

  sysclk_power #(
    .WAKE_FAST (WAKE_FAST),
    .WAKE_SUB0 (WAKE_SUB0),
    .WAKE_SUB1 (WAKE_SUB1)
  ) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .wait_req (wait_req),
    .stop_req (stop_req),
    .wake_evt (wake_evt),
    .src_tick (sel_tk),
    .low_mode (low_mode),
    .cnt_sel  (cnt_sel),
    .st_q     (st_q),
    .st_nxt   (st_nxt)
  );
endmodule

// File: rtl/sysclk_mode_ctrl_chk.sv
module sysclk_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       clk_en,
  input logic [5:0] ctrl_q,
  input logic       err_flag,
  input logic       main_ready,
  input logic [1:0] pwr_state,
  input logic       rc_on,
  input logic       main_on,
  input logic       sub_on
);
  // R6
  div_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[1:0] != 2'b11);

  // R5
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_q) |-> $countones(ctrl_q ^ $past(ctrl_q)) == 1);

  // R11
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'd2 |-> !clk_en && !rc_on && !main_on && !sub_on);

  // R11
  stop_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_state) == 2'd2 |-> $stable(ctrl_q));

  // R10
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'd1 |-> !clk_en);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(wr_en) && $stable(ctrl_q));

  // R8
  main_sel_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[2]) |-> main_ready);
endmodule

bind sysclk_mode_ctrl sysclk_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .clk_en     (clk_en),
  .ctrl_q     (ctrl_q),
  .err_flag   (err_flag),
  .main_ready (main_ready),
  .pwr_state  (pwr_state),
  .rc_on      (rc_on),
  .main_on    (main_on),
  .sub_on     (sub_on)
);

// File: tb/sysclk_mode_ctrl_tb_top.sv
module sysclk_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic       err_clr = 1'b0;
  logic       cnt_sel = 1'b0;
  logic       wait_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic       rc_tick = 1'b0;
  logic       main_tick = 1'b0;
  logic       sub_tick = 1'b0;
  logic       clk_en;
  logic [5:0] ctrl_q;
  logic       err_flag;
  logic       main_ready;
  logic [1:0] pwr_state;
  logic       rc_on;
  logic       main_on;
  logic       sub_on;

  always #10 clk = ~clk;

  sysclk_mode_ctrl #(
    .STAB_TICKS (4),
    .WAKE_FAST  (6),
    .WAKE_SUB0  (3),
    .WAKE_SUB1  (10)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .err_clr(err_clr), .cnt_sel(cnt_sel), .wait_req(wait_req),
    .stop_req(stop_req), .wake_evt(wake_evt), .rc_tick(rc_tick),
    .main_tick(main_tick), .sub_tick(sub_tick), .clk_en(clk_en),
    .ctrl_q(ctrl_q), .err_flag(err_flag), .main_ready(main_ready),
    .pwr_state(pwr_state), .rc_on(rc_on), .main_on(main_on), .sub_on(sub_on)
  );

  typedef struct {
    string req;
    int    sel;
    int    exp;
    int    given;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    pulses = 0;
  bit    done = 1'b0;

  always @(posedge clk) if (clk_en) pulses <= pulses + 1;

  function automatic int observe(int sel, int given);
    case (sel)
      0: return int'(ctrl_q);
      1: return int'(err_flag);
      2: return int'(pwr_state);
      3: return int'(main_ready);
      4: return int'({rc_on, main_on, sub_on});
      default: return given;
    endcase
  endfunction

  initial forever begin
    @(mon_ev);
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = observe(it.sel, it.given);
      n_cmp++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_v(string req, int sel, int exp, int given = 0);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp; it.given = given;
    q.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic write_w(logic [5:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic ticks(int which, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which == 0) rc_tick = 1'b1;
      else if (which == 1) main_tick = 1'b1;
      else sub_tick = 1'b1;
      @(negedge clk);
      rc_tick = 1'b0; main_tick = 1'b0; sub_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic count_ticks(string req, int which, int n, int exp);
    int base;
    base = pulses;
    ticks(which, n);
    expect_v(req, 9, exp, pulses - base);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_v("R1 ctrl", 0, 'h11);
    expect_v("R1 err", 1, 0);
    expect_v("R1 state", 2, 0);
    expect_v("R1 ready", 3, 0);
    expect_v("R4 osc enables", 4, 3'b100);
    count_ticks("R2 middle rc", 0, 16, 2);
    count_ticks("R4 main off ignored", 1, 8, 0);
    count_ticks("R3 sub unselected", 2, 8, 0);

    write_w(6'h13);
    expect_v("R6 div11 refused ctrl", 0, 'h11);
    expect_v("R9 err set", 1, 1);
    pulse(err_clr);
    expect_v("R9 err cleared", 1, 0);

    write_w(6'h10);
    expect_v("R2 high accepted", 0, 'h10);
    count_ticks("R2 high rc", 0, 8, 4);

    write_w(6'h12);
    expect_v("R7 low needs sub", 0, 'h10);
    write_w(6'h1C);
    expect_v("R5 two bits refused", 0, 'h10);
    write_w(6'h10);
    expect_v("R5 no change refused", 1, 1);
    pulse(err_clr);

    write_w(6'h18);
    expect_v("R4 sub on", 4, 3'b101);
    write_w(6'h1A);
    expect_v("R7 low entered", 0, 'h1A);
    count_ticks("R2 low sub", 2, 4, 2);
    count_ticks("R3 rc ignored in low", 0, 4, 0);
    write_w(6'h12);
    expect_v("R7 sub stop in low refused", 0, 'h1A);

    write_w(6'h1E);
    expect_v("R8 main stopped refused", 0, 'h1A);
    write_w(6'h0A);
    expect_v("R8 main started", 0, 'h0A);
    write_w(6'h0E);
    expect_v("R8 unstable refused", 0, 'h0A);
    ticks(1, 3);
    expect_v("R8 ready not yet", 3, 0);
    ticks(1, 1);
    expect_v("R8 ready after stab", 3, 1);
    write_w(6'h0E);
    expect_v("R8 main select", 0, 'h0E);
    write_w(6'h0C);
    expect_v("R7 leave low to main", 0, 'h0C);
    count_ticks("R3 high main", 1, 4, 2);
    write_w(6'h2C);
    expect_v("R4 rc stopped", 4, 3'b011);
    count_ticks("R4 rc ticks ignored", 0, 4, 0);
    write_w(6'h3C);
    expect_v("R7 main in use refused", 0, 'h2C);
    pulse(err_clr);

    pulse(stop_req);
    expect_v("R11 stop state", 2, 2);
    expect_v("R11 osc off", 4, 0);
    count_ticks("R11 no clk in stop", 1, 4, 0);
    write_w(6'h0C);
    expect_v("R11 write refused", 1, 1);
    pulse(wake_evt);
    expect_v("R12 wake state", 2, 3);
    ticks(1, 5);
    expect_v("R12 still waking", 2, 3);
    ticks(1, 1);
    expect_v("R12 back to run", 2, 0);
    expect_v("R12 ctrl kept", 0, 'h2C);

    write_w(6'h2E);
    expect_v("R7 low from main", 0, 'h2E);
    cnt_sel = 1'b0;
    pulse(stop_req);
    pulse(wake_evt);
    ticks(2, 2);
    expect_v("R13 short still", 2, 3);
    ticks(2, 1);
    expect_v("R13 short done", 2, 0);
    cnt_sel = 1'b1;
    pulse(stop_req);
    pulse(wake_evt);
    ticks(2, 9);
    expect_v("R13 long still", 2, 3);
    ticks(2, 1);
    expect_v("R13 long done", 2, 0);

    pulse(wait_req);
    expect_v("R10 wait state", 2, 1);
    expect_v("R10 osc run", 4, 3'b011);
    count_ticks("R10 no clk in wait", 2, 4, 0);
    pulse(wake_evt);
    expect_v("R10 back to run", 2, 0);
    expect_v("R10 ctrl kept", 0, 'h2E);
    count_ticks("R10 clk resumes", 2, 4, 2);

    done = 1'b1;
    #1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule